// File: doc/BRIEF.md
# PCI Hotplug Slot Event Controller

This block is a small register window in I/O space that carries slot hotplug signalling for one PCI bus. The platform side raises per-slot insert and remove requests. The block collects these requests in two 32-bit status words, one for slots coming up and one for slots going down. It also drives a general-purpose event line toward the host for as long as either word holds a pending bit. Host software reads a status word to collect the pending bits, and that read clears the word.

To remove a device, software first writes the bus number into a select register. It then writes a one-hot slot mask (1 shifted left by the slot number) to the eject register. The block answers with a one-cycle pulse on each slot whose mask bit is set. The selected bus number is presented next to the pulses, so the platform can tell which bus the command is for.

All accesses are whole 32-bit dwords. The byte offsets within the window are:

| Offset | Register |
|--------|----------|
| 0x00 | up status word |
| 0x04 | down status word |
| 0x08 | eject mask |
| 0x10 | bus select |

Top module: `hp_slot_evt_ctrl`

## Requirements
- R1: While `rst_n` is low, both status words and the bus select return to zero, `gpe_evt` is low, `eject_pulse` is zero and `io_rdata` is zero.
- R2: When `ins_req[i]` is high at a clock edge, bit i of the up status word (byte offset 0x00) is set from that edge onward.
- R3: When `rem_req[i]` is high at a clock edge, bit i of the down status word (byte offset 0x04) is set from that edge onward.
- R4: A read of offset 0x00 or 0x04 returns the word's current value and clears the word. A request bit that arrives at the same edge as the read is kept for the next read.
- R5: A write to offset 0x08 makes `eject_pulse` equal to the bits written, for exactly the one cycle after the write edge. Zero bits pulse nothing, so a write of zero leaves `eject_pulse` at zero.
- R6: A write to offset 0x10 stores the full 32-bit bus number. That value appears on `eject_bus` and reads back at offset 0x10. It holds until the next write to 0x10.
- R7: `gpe_evt` is high while either status word is nonzero. It falls after the edge at which the last nonzero word is read. It never rises without an insert or remove request at the edge before.
- R8: Reads of offset 0x08, of 0x0C, of 0x14 to 0x1C, and of any address whose two low bits are not zero return zero. Writes to 0x00 or 0x04 change neither status word.
- R9: `io_rdata` is registered. It carries the read result in the cycle after the edge that samples `io_rd`, and it is zero in every cycle after an edge with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W (5) | Byte offset within the I/O window |
| io_rd | input | 1 | Dword read strobe |
| io_wr | input | 1 | Dword write strobe |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Registered read data |
| ins_req | input | SLOTS (32) | Per-slot insertion request |
| rem_req | input | SLOTS (32) | Per-slot removal request |
| eject_pulse | output | SLOTS (32) | One-cycle per-slot eject strobe |
| eject_bus | output | 32 | Currently selected bus number |
| gpe_evt | output | 1 | General-purpose event toward the host |

## Verification
Every result of this block appears one edge after its cause.

- **Status bits.** A request sets its bit at the next edge, and `gpe_evt` follows at that same edge.
- **Eject.** An eject write shows on `eject_pulse` after its edge and is gone one edge later.
- **Reads.** A read's data shows on `io_rdata` after the edge that samples `io_rd`.

The bench drives all inputs on the falling edge and samples outputs on the falling edge that follows the relevant rising edge. Read results go through a queue: a monitor compares each one in the half-cycle after the edge that took the read. The same-edge insert-and-read case is driven in one cycle to check that the new bit survives the clear.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int DW      = 32;
  localparam int IDX_UP  = 0;  // byte 0x00
  localparam int IDX_DN  = 1;  // byte 0x04
  localparam int IDX_EJ  = 2;  // byte 0x08
  localparam int IDX_BUS = 4;  // byte 0x10
endpackage

// File: rtl/hp_io_dec.sv
module hp_io_dec #(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              up_rd_o,
  output logic              dn_rd_o,
  output logic              bus_rd_o,
  output logic              ej_wr_o,
  output logic              bus_wr_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] word_idx;

  always_comb begin
    aligned  = (addr_i[1:0] == 2'b00);
    word_idx = addr_i[ADDR_W-1:2];
    up_rd_o  = rd_i && aligned && (word_idx == IDX_W'(hp_pkg::IDX_UP));
    dn_rd_o  = rd_i && aligned && (word_idx == IDX_W'(hp_pkg::IDX_DN));
    bus_rd_o = rd_i && aligned && (word_idx == IDX_W'(hp_pkg::IDX_BUS));
    ej_wr_o  = wr_i && aligned && (word_idx == IDX_W'(hp_pkg::IDX_EJ));
    bus_wr_o = wr_i && aligned && (word_idx == IDX_W'(hp_pkg::IDX_BUS));
  end
endmodule

// File: rtl/hp_stat_word.sv
module hp_stat_word #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_q, word_d;
  logic         word_en;

  always_comb begin
    word_en = clr_i || (|set_i);
    word_d  = (clr_i ? '0 : word_q) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign word_o = word_q;

  // R2 / R3: a request bit is present after its edge
  p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((word_q & $past(set_i)) == $past(set_i)));

  // R4: read with no new request leaves the word empty
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i == '0) |=> (word_q == '0));

  // R3: without a request or a read the word holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && set_i == '0) |=> $stable(word_q));
endmodule

// File: rtl/hp_eject.sv
module hp_eject #(
  parameter int SLOTS = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ej_wr_i,
  input  logic                   bus_wr_i,
  input  logic [hp_pkg::DW-1:0]  wdata_i,
  output logic [SLOTS-1:0]       pulse_o,
  output logic [hp_pkg::DW-1:0]  bus_o
);
  logic [SLOTS-1:0]      pulse_q, pulse_d;
  logic [hp_pkg::DW-1:0] bus_q, bus_d;

  always_comb begin
    pulse_d = ej_wr_i ? wdata_i[SLOTS-1:0] : '0;
    bus_d   = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_q <= '0;
    else if (bus_wr_i) bus_q <= bus_d;
  end

  assign pulse_o = pulse_q;
  assign bus_o   = bus_q;

  // R5: no pulse without an eject write at the edge before
  p_pulse_only_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ej_wr_i |=> (pulse_o == '0));

  // R6: bus select holds between writes
  p_bus_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_i |=> $stable(bus_o));
endmodule

// File: rtl/hp_slot_evt_ctrl.sv
module hp_slot_evt_ctrl #(
  parameter int SLOTS  = 32,
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     io_addr,
  input  logic                  io_rd,
  input  logic                  io_wr,
  input  logic [hp_pkg::DW-1:0] io_wdata,
  output logic [hp_pkg::DW-1:0] io_rdata,
  input  logic [SLOTS-1:0]      ins_req,
  input  logic [SLOTS-1:0]      rem_req,
  output logic [SLOTS-1:0]      eject_pulse,
  output logic [hp_pkg::DW-1:0] eject_bus,
  output logic                  gpe_evt
);
  logic up_rd, dn_rd, bus_rd, ej_wr, bus_wr;
  logic [SLOTS-1:0]      up_word, dn_word;
  logic [hp_pkg::DW-1:0] up_ext, dn_ext, rdata_d, rdata_q;

  hp_io_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(io_addr), .rd_i(io_rd), .wr_i(io_wr),
    .up_rd_o(up_rd), .dn_rd_o(dn_rd), .bus_rd_o(bus_rd),
    .ej_wr_o(ej_wr), .bus_wr_o(bus_wr)
  );

  hp_stat_word #(.W(SLOTS)) u_up (
    .clk(clk), .rst_n(rst_n), .set_i(ins_req), .clr_i(up_rd), .word_o(up_word)
  );

  hp_stat_word #(.W(SLOTS)) u_dn (
    .clk(clk), .rst_n(rst_n), .set_i(rem_req), .clr_i(dn_rd), .word_o(dn_word)
  );

  hp_eject #(.SLOTS(SLOTS)) u_ej (
    .clk(clk), .rst_n(rst_n), .ej_wr_i(ej_wr), .bus_wr_i(bus_wr),
    .wdata_i(io_wdata), .pulse_o(eject_pulse), .bus_o(eject_bus)
  );

  always_comb begin
    up_ext = '0;
    dn_ext = '0;
    up_ext[SLOTS-1:0] = up_word;
    dn_ext[SLOTS-1:0] = dn_word;
    if (up_rd)       rdata_d = up_ext;
    else if (dn_rd)  rdata_d = dn_ext;
    else if (bus_rd) rdata_d = eject_bus;
    else             rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign io_rdata = rdata_q;
  assign gpe_evt  = (|up_word) || (|dn_word);

  // R7: the event only rises after a platform request
  p_evt_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gpe_evt) |-> $past((|ins_req) || (|rem_req)));

  // R9: read data is zero after an edge without a read
  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> (io_rdata == '0));

  // R8: writes to status offsets never raise the event on their own
  p_status_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gpe_evt && ins_req == '0 && rem_req == '0) |=> !gpe_evt);
endmodule

// File: tb/hp_slot_evt_ctrl_tb.sv
module hp_slot_evt_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic [SLOTS-1:0] ins_req = '0, rem_req = '0;
  logic [SLOTS-1:0] eject_pulse;
  logic [31:0] eject_bus;
  logic        gpe_evt;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hp_slot_evt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .ins_req(ins_req), .rem_req(rem_req),
    .eject_pulse(eject_pulse), .eject_bus(eject_bus), .gpe_evt(gpe_evt)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: read results are due in the half cycle after the sampling edge
  always @(posedge clk) rd_seen <= io_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(io_rdata === e, t, io_rdata, e);
    end
  end

  task automatic io_read(input logic [4:0] a, input logic [31:0] e, input string t);
    io_addr = a; io_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic io_write(input logic [4:0] a, input logic [31:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(gpe_evt === 1'b0, "R1 gpe in reset", {31'b0, gpe_evt}, 32'h0);
    chk(eject_pulse === '0, "R1 eject in reset", eject_pulse, 32'h0);
    chk(eject_bus === '0, "R1 bus in reset", eject_bus, 32'h0);
    chk(io_rdata === '0, "R1 rdata in reset", io_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    io_read(5'h00, 32'h0, "R1 up word after reset");
    io_read(5'h04, 32'h0, "R1 down word after reset");

    // R2 insert
    ins_req = (32'h1 << 3) | (32'h1 << 17);
    @(negedge clk);
    ins_req = '0;
    chk(gpe_evt === 1'b1, "R7 gpe after insert", {31'b0, gpe_evt}, 32'h1);
    io_read(5'h00, 32'h0002_0008, "R2 up bits");
    chk(gpe_evt === 1'b0, "R7 gpe low after clear", {31'b0, gpe_evt}, 32'h0);
    io_read(5'h00, 32'h0, "R4 up cleared by read");

    // R3 remove plus concurrent insert
    rem_req = 32'h8000_0000; ins_req = 32'h1;
    @(negedge clk);
    rem_req = '0; ins_req = '0;
    io_read(5'h04, 32'h8000_0000, "R3 down bit");
    chk(gpe_evt === 1'b1, "R7 gpe held by other word", {31'b0, gpe_evt}, 32'h1);
    io_read(5'h00, 32'h1, "R2 up bit slot 0");
    chk(gpe_evt === 1'b0, "R7 gpe low after both read", {31'b0, gpe_evt}, 32'h0);

    // R4 request on the read edge survives
    ins_req = 32'h20;
    @(negedge clk);
    ins_req = 32'h200;
    io_read(5'h00, 32'h20, "R4 read returns old value");
    ins_req = '0;
    io_read(5'h00, 32'h200, "R4 same-edge insert kept");

    // R6 bus select, R5 eject
    io_write(5'h10, 32'h0000_005A);
    chk(eject_bus === 32'h5A, "R6 eject_bus", eject_bus, 32'h5A);
    io_read(5'h10, 32'h5A, "R6 bus readback");
    io_write(5'h08, 32'h80);
    chk(eject_pulse === 32'h80, "R5 eject pulse", eject_pulse, 32'h80);
    chk(eject_bus === 32'h5A, "R6 bus with pulse", eject_bus, 32'h5A);
    @(negedge clk);
    chk(eject_pulse === 32'h0, "R5 pulse one cycle", eject_pulse, 32'h0);
    io_write(5'h08, 32'h0);
    chk(eject_pulse === 32'h0, "R5 zero mask no pulse", eject_pulse, 32'h0);

    // R8 ignored writes, unused offsets
    io_write(5'h00, 32'hFFFF_FFFF);
    io_write(5'h04, 32'hFFFF_FFFF);
    chk(gpe_evt === 1'b0, "R8 status write no event", {31'b0, gpe_evt}, 32'h0);
    io_read(5'h00, 32'h0, "R8 up unchanged by write");
    io_read(5'h04, 32'h0, "R8 down unchanged by write");
    io_read(5'h08, 32'h0, "R8 eject reads zero");
    io_read(5'h0C, 32'h0, "R8 0x0C zero");
    io_read(5'h14, 32'h0, "R8 0x14 zero");
    io_read(5'h1C, 32'h0, "R8 0x1C zero");
    io_read(5'h12, 32'h0, "R8 misaligned zero");

    // R9 idle data
    @(negedge clk);
    chk(io_rdata === 32'h0, "R9 rdata idle", io_rdata, 32'h0);
    @(negedge clk);
    finish_run();
  end
endmodule